// File: doc/BRIEF.md
# Timer Compare Unit with Force Strobe

An 8-bit timer/counter with a single output compare channel that drives one waveform pin. The counter advances on a one-cycle tick supplied by an external clock-select block, compares itself against a programmable value on each tick, and on a match sets an interrupt flag and applies a selectable action to the waveform pin.

Software reaches the block through a simple register bus. It can load the counter, program the compare value and pick the operating mode and the output action. It can also fire a force strobe, which applies the output action at once without a real match. A counter write removes the compare match from the next tick, so reloading the counter cannot produce a spurious match.

Top module: `tcu_top`

## Requirements
- R1: After reset the counter, compare value, control register, waveform output and flag are all zero.
- R2: Register addresses are: 0 counter, 1 compare value, 2 control, 3 status. Control bits: [1:0] output action, [2] force strobe, [4:3] mode. Status bit 0 is the flag. The force bit always reads as zero.
- R3: Each cycle with tick_i high and no counter write increments the counter. In normal mode (00) and PWM modes (1x) it wraps from 255 to 0. Without a tick or a write the counter holds.
- R4: A tick on which the counter equals the compare value is a match. A match sets the flag and applies the output action to wave_o: 00 keep, 01 toggle, 10 drive low, 11 drive high. The result is visible after that clock edge.
- R5: In CTC mode (01), a matching tick loads the counter with 0 instead of incrementing it.
- R6: A counter write wins over a tick in the same cycle. The next tick after a counter write never produces a match.
- R7: A control write with bit 2 set and mode bit 4 clear applies the output action given in that same write. It does not set the flag and does not change the counter, even in CTC mode.
- R8: In PWM modes (written mode 1x) the force strobe has no effect on wave_o.
- R9: Writing 1 to status bit 0 clears the flag.
- R10: When a force strobe and a real match fall in the same cycle, wave_o takes one action, using the action field of the force write. The flag is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle count enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 8 | Read data (combinational) |
| cnt_o | output | 8 | Counter value |
| wave_o | output | 1 | Waveform output |
| flag_o | output | 1 | Compare-match flag |

## Verification
Every result is registered, so each one lands one edge after its cause. A tick or write at edge k shows on cnt_o, wave_o and flag_o after edge k, while readback is combinational on the registered state. The bench drives all stimulus on the falling edge. It samples on the next falling edge after the last stimulus cycle, so each check sees exactly one update. Block and force cases put the write and the tick in the same or adjacent cycles on purpose, so the bench can tell which event won.

// File: rtl/tcu_pkg.sv
package tcu_pkg;
  typedef enum logic [1:0] {COM_KEEP = 2'b00, COM_TOG = 2'b01, COM_CLR = 2'b10, COM_SET = 2'b11} com_e;
  typedef enum logic [1:0] {MODE_NORM = 2'b00, MODE_CTC = 2'b01, MODE_PWM = 2'b10, MODE_PWM_B = 2'b11} mode_e;
  localparam logic [1:0] A_CNT = 2'd0;
  localparam logic [1:0] A_CMP = 2'd1;
  localparam logic [1:0] A_CTL = 2'd2;
  localparam logic [1:0] A_STS = 2'd3;
  localparam int CTL_FRC = 2;
  localparam int CTL_MODE_LO = 3;
endpackage

// File: rtl/tcu_regs.sv
module tcu_regs
  import tcu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_addr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic [1:0]   rd_addr_i,
  input  logic [W-1:0] cnt_i,
  input  logic         flag_i,
  output logic [W-1:0] cmp_o,
  output com_e         com_o,
  output mode_e        mode_o,
  output logic         cnt_we_o,
  output logic         frc_o,
  output com_e         frc_com_o,
  output logic         flag_clr_o,
  output logic [W-1:0] rd_data_o
);
  logic ctl_we;
  mode_e wr_mode;

  assign ctl_we     = wr_en_i && (wr_addr_i == A_CTL);
  assign wr_mode    = mode_e'(wr_data_i[CTL_MODE_LO+1:CTL_MODE_LO]);
  assign cnt_we_o   = wr_en_i && (wr_addr_i == A_CNT);
  assign flag_clr_o = wr_en_i && (wr_addr_i == A_STS) && wr_data_i[0];
  // force acts only when the mode written alongside it is non-PWM
  assign frc_o      = ctl_we && wr_data_i[CTL_FRC] && !wr_mode[1];
  assign frc_com_o  = com_e'(wr_data_i[1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_o  <= '0;
      com_o  <= COM_KEEP;
      mode_o <= MODE_NORM;
    end else begin
      if (wr_en_i && (wr_addr_i == A_CMP)) cmp_o <= wr_data_i;
      if (ctl_we) begin
        com_o  <= com_e'(wr_data_i[1:0]);
        mode_o <= wr_mode;
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      A_CNT: rd_data_o = cnt_i;
      A_CMP: rd_data_o = cmp_o;
      A_CTL: rd_data_o[CTL_MODE_LO+1:0] = {mode_o, 1'b0, com_o};
      default: rd_data_o[0] = flag_i;
    endcase
  end

  p_ctl_update_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we |=> (com_o == $past(wr_data_i[1:0])));
endmodule

// File: rtl/tcu_counter.sv
module tcu_counter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] cmp_i,
  input  logic         ctc_i,
  output logic [W-1:0] cnt_o,
  output logic         match_o
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
  logic blk_q;

  assign match_o = tick_i && !we_i && !blk_q && (cnt_o == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      blk_q <= 1'b0;
    end else if (we_i) begin
      cnt_o <= wdata_i;
      blk_q <= 1'b1;
    end else if (tick_i) begin
      blk_q <= 1'b0;
      cnt_o <= (ctc_i && match_o) ? '0 : cnt_o + 1'b1;
    end
  end

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !we_i) |=> $stable(cnt_o));
  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !we_i && !ctc_i && cnt_o == CNT_MAX) |=> (cnt_o == '0));
  p_ctc_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctc_i && match_o) |=> (cnt_o == '0));
  p_write_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (cnt_o == $past(wdata_i)));
  p_block_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i ##1 (tick_i && !we_i)) |-> !match_o);
endmodule

// File: rtl/tcu_wave.sv
module tcu_wave
  import tcu_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic match_i,
  input  logic frc_i,
  input  com_e frc_com_i,
  input  com_e com_i,
  input  logic flag_clr_i,
  output logic wave_o,
  output logic flag_o
);
  com_e act;
  logic fire;

  // force overrides the stored action so a coincident match acts once
  assign act  = frc_i ? frc_com_i : com_i;
  assign fire = frc_i || match_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wave_o <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      if (fire) begin
        unique case (act)
          COM_TOG: wave_o <= !wave_o;
          COM_CLR: wave_o <= 1'b0;
          COM_SET: wave_o <= 1'b1;
          default: wave_o <= wave_o;
        endcase
      end
      if (match_i)         flag_o <= 1'b1;
      else if (flag_clr_i) flag_o <= 1'b0;
    end
  end

  p_flag_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i |=> flag_o);
  p_force_no_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frc_i && !match_i && !flag_clr_i) |=> (flag_o == $past(flag_o)));
  p_idle_wave_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!match_i && !frc_i) |=> $stable(wave_o));
  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !match_i) |=> !flag_o);
endmodule

// File: rtl/tcu_top.sv
module tcu_top
  import tcu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_addr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic [1:0]   rd_addr_i,
  output logic [W-1:0] rd_data_o,
  output logic [W-1:0] cnt_o,
  output logic         wave_o,
  output logic         flag_o
);
  logic [W-1:0] cmp;
  com_e  com, frc_com;
  mode_e mode;
  logic cnt_we, frc, flag_clr, match;

  tcu_regs #(.W(W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i,
    .cnt_i(cnt_o), .flag_i(flag_o), .cmp_o(cmp), .com_o(com), .mode_o(mode),
    .cnt_we_o(cnt_we), .frc_o(frc), .frc_com_o(frc_com),
    .flag_clr_o(flag_clr), .rd_data_o
  );

  tcu_counter #(.W(W)) u_cnt (
    .clk_i, .rst_ni, .tick_i, .we_i(cnt_we), .wdata_i(wr_data_i),
    .cmp_i(cmp), .ctc_i(mode == MODE_CTC), .cnt_o, .match_o(match)
  );

  tcu_wave u_wave (
    .clk_i, .rst_ni, .match_i(match), .frc_i(frc), .frc_com_i(frc_com),
    .com_i(com), .flag_clr_i(flag_clr), .wave_o, .flag_o
  );

  p_pwm_force_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_CTL && wr_data_i[CTL_MODE_LO+1] && !match) |=> $stable(wave_o));
  p_force_cnt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frc && !tick_i && !cnt_we) |=> $stable(cnt_o));
endmodule

// File: tb/tcu_top_tb.sv
module tcu_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data, cnt;
  logic       wave, flag;
  int n_run = 0, n_fail = 0, cyc = 0;

  always #5 clk = !clk;

  tcu_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .cnt_o(cnt), .wave_o(wave), .flag_o(flag)
  );

  // {mode, com, cmp, cnt0, ticks, exp_cnt, exp_wave, exp_flag}
  localparam logic [37:0] VEC [6] = '{
    {2'b00, 2'b01, 8'd5,  8'd3,   8'd3, 8'd6,  1'b1, 1'b1},  // R4 toggle
    {2'b01, 2'b11, 8'd4,  8'd2,   8'd3, 8'd0,  1'b1, 1'b1},  // R5 CTC set
    {2'b00, 2'b00, 8'd10, 8'd8,   8'd3, 8'd11, 1'b0, 1'b1},  // R4 keep
    {2'b00, 2'b01, 8'd0,  8'd254, 8'd3, 8'd1,  1'b1, 1'b1},  // R3 wrap
    {2'b00, 2'b01, 8'd7,  8'd7,   8'd1, 8'd8,  1'b0, 1'b0},  // R6 blocked
    {2'b10, 2'b01, 8'd3,  8'd1,   8'd3, 8'd4,  1'b1, 1'b1}   // R4 PWM
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic tk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; tick = tk;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] r;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cnt", cnt, 8'd0);
    chk("R1 wave", {7'd0, wave}, 8'd0);
    chk("R1 flag", {7'd0, flag}, 8'd0);
    rd(2'd2, r); chk("R1 ctl", r, 8'd0);
    rd(2'd1, r); chk("R1 cmp", r, 8'd0);

    foreach (VEC[i]) begin
      logic [37:0] v;
      v = VEC[i];
      wr(2'd2, 8'h06, 1'b0);            // normal mode, force drive low
      wr(2'd3, 8'h01, 1'b0);
      wr(2'd1, v[33:26], 1'b0);
      wr(2'd2, {3'b0, v[37:36], 1'b0, v[35:34]}, 1'b0);
      wr(2'd0, v[25:18], 1'b0);
      ticks(int'(v[17:10]));
      chk($sformatf("R3/R4 vec%0d cnt", i), cnt, v[9:2]);
      chk($sformatf("R4 vec%0d wave", i), {7'd0, wave}, {7'd0, v[1]});
      chk($sformatf("R4/R6 vec%0d flag", i), {7'd0, flag}, {7'd0, v[0]});
    end

    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    wr(2'd2, 8'h05, 1'b0);               // R7 force toggle, normal mode
    chk("R7 force wave", {7'd0, wave}, 8'd1);
    chk("R7 force flag", {7'd0, flag}, 8'd0);
    rd(2'd2, r); chk("R2 force reads zero", r, 8'h01);
    wr(2'd0, 8'd9, 1'b0);
    wr(2'd2, 8'h0E, 1'b0);               // R7 CTC, force drive low
    chk("R7 force wave clr", {7'd0, wave}, 8'd0);
    chk("R7 force keeps cnt", cnt, 8'd9);
    wr(2'd2, 8'h17, 1'b0);               // R8 PWM, force drive high
    chk("R8 pwm force ignored", {7'd0, wave}, 8'd0);
    rd(2'd2, r); chk("R2 ctl readback", r, 8'h13);

    wr(2'd2, 8'h01, 1'b0);
    wr(2'd1, 8'd5, 1'b0);
    wr(2'd0, 8'd4, 1'b0);
    ticks(1);
    wr(2'd2, 8'h05, 1'b1);               // R10 force + match same cycle
    chk("R10 single toggle", {7'd0, wave}, 8'd1);
    chk("R10 flag set", {7'd0, flag}, 8'd1);
    chk("R10 cnt", cnt, 8'd6);
    wr(2'd3, 8'h01, 1'b0);
    chk("R9 flag cleared", {7'd0, flag}, 8'd0);
    rd(2'd3, r); chk("R9 status read", r, 8'd0);
    wr(2'd0, 8'd20, 1'b1);               // R6 write beats tick
    chk("R6 write wins", cnt, 8'd20);
    repeat (3) @(negedge clk);
    chk("R3 hold without tick", cnt, 8'd20);
    rd(2'd0, r); chk("R2 cnt readback", r, 8'd20);
    finish_run();
  end
endmodule